// File: doc/BRIEF.md
# Real-Time Clock Prescaler with Update Warning Window

This block is the timing generator for a real-time clock. An enable pulse at the 32.768 kHz oscillator rate drives a 15-stage binary divider. One wrap of the divider marks one second. At that moment the block sends a single-cycle count strobe to the digit counter chain. An active-low busy flag warns a host that the counters are about to change. After a short grace period, an access-inhibit level tells the host that reads and writes are no longer safe. The block also drives a 4-bit vector of reference waveforms: a 1024 Hz square wave and active-low marker pulses at one per second, one per minute and one per hour.

A clear request holds only the upper five divider stages and the busy logic. The lower ten stages keep running, so after release the next second arrives one second later, give or take the phase of the low stages. A halt input stops the count strobe and the minute and hour markers, but the divider keeps running. The minute and hour markers come from look-ahead carry levels supplied by the counter chain: a seconds-at-59 level and a minutes-and-seconds-at-59 level. They start on the same tick as the one-second marker.

All outputs are registered in the system clock domain. "Tick" below means a system clock edge at which `osc_tick` is high.

Top module: `rtc_prescaler`

## Requirements
- R1: `cnt_strobe` is high for exactly one cycle, in the cycle after the tick that takes the divider from 32767 to 0. With ticks on every clock, successive strobes are 32768 cycles apart.
- R2: While `halt` is high at the wrapping tick, `cnt_strobe` stays low. The divider and `busy_n` keep running.
- R3: `busy_n` is low while the divider value is in 32754..32767, which is the last 14 ticks before the wrap. It is high otherwise, and returns high with the wrap.
- R4: `acc_inhibit` is high while the divider value is in 32762..32767. This leaves the first 8 ticks of the busy window as a grace period. `acc_inhibit` is never high while `busy_n` is high.
- R5: While `div_clr` is high, divider stages 11 to 15 are held at zero and `busy_n` is high. `acc_inhibit`, `cnt_strobe` and markers bits 1 to 3 of `ref_out` are held inactive.
- R6: Stages 1 to 10 keep counting during `div_clr`. After release, with a tick on every clock, the first strobe appears 32768 − L cycles later, where L is the value of the low ten stages at release.
- R7: `ref_out[0]` is the 1024 Hz wave. It is high while divider bit 4 is 0 and low while it is 1, so it spends 16 ticks in each state, and it does not stop during `div_clr`.
- R8: `ref_out[1]` goes low for 4 ticks starting with every wrap, whether `halt` is high or low.
- R9: `ref_out[2]` goes low for 4 ticks starting with a wrap at which `sec_carry` is high and `halt` is low. `ref_out[3]` does the same with `min_carry`.
- R10: While `rst_n` is low: divider = 0, `cnt_strobe` = 0, `busy_n` = 1, `acc_inhibit` = 0, `ref_out` = 4'b1111.
- R11: With `osc_tick` low, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle enable at the oscillator rate |
| div_clr | input | 1 | Holds upper divider stages and busy logic cleared |
| halt | input | 1 | Suppresses count strobe and minute/hour markers |
| sec_carry | input | 1 | Seconds digit will carry at next count |
| min_carry | input | 1 | Minutes digit will carry at next count |
| cnt_strobe | output | 1 | One-cycle count pulse to the counter chain |
| busy_n | output | 1 | Active-low update warning |
| acc_inhibit | output | 1 | Host access unsafe |
| ref_out | output | 4 | Reference waveforms: 1024 Hz, second, minute and hour markers |

## Verification
Every output of this block is due at the same clock edge as the tick that causes it. The strobe, busy, inhibit and marker levels all appear one register after the divider's next value is formed. The bench model advances its divider and marker counters at each rising edge and compares all outputs at the following falling edge, so no result has to wait a further cycle. The two interval checks count falling edges from the stimulus: 32768 cycles for back-to-back strobes, and 32768 − L cycles after a clear is released. In both checks, ticks run on every clock.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int REF_FAST = 0;
   localparam int REF_SEC  = 1;
   localparam int REF_MIN  = 2;
   localparam int REF_HOUR = 3;
   localparam int REF_N    = 4;

   typedef logic [REF_N-1:0] ref_vec_t;
endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
   parameter int STAGES      = 15,
   parameter int HOLD_STAGES = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              clr,
   output logic [STAGES-1:0] q_nxt,
   output logic              wrap
);
   localparam int LO_W = STAGES - HOLD_STAGES;

   logic [STAGES-1:0] q;

   generate
      if (LO_W == 0) begin : g_full_clear
         assign q_nxt = clr ? '0 : q + STAGES'(tick);
      end else begin : g_split_clear
         logic [LO_W-1:0]        lo_nxt;
         logic [HOLD_STAGES-1:0] hi_nxt;
         logic                   lo_carry;
         always_comb begin
            lo_carry = tick & (&q[LO_W-1:0]);
            lo_nxt   = q[LO_W-1:0] + LO_W'(tick);
            hi_nxt   = clr ? '0 : q[STAGES-1:LO_W] + HOLD_STAGES'(lo_carry);
         end
         assign q_nxt = {hi_nxt, lo_nxt};
      end
   endgenerate

   assign wrap = tick & ~clr & (&q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= q_nxt;
   end
endmodule

// File: rtl/rtc_busy_window.sv
module rtc_busy_window #(
   parameter int STAGES = 15,
   parameter int LEAD   = 14,
   parameter int GRACE  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [STAGES-1:0] q_nxt,
   output logic              busy_n,
   output logic              inhibit
);
   localparam int unsigned OPEN_I = (1 << STAGES) - LEAD;
   localparam int unsigned LOCK_I = OPEN_I + GRACE;
   localparam logic [STAGES-1:0] OPEN_AT = STAGES'(OPEN_I);
   localparam logic [STAGES-1:0] LOCK_AT = STAGES'(LOCK_I);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_n  <= 1'b1;
         inhibit <= 1'b0;
      end else begin
         busy_n  <= clr | (q_nxt < OPEN_AT);
         inhibit <= ~clr & (q_nxt >= LOCK_AT);
      end
   end
endmodule

// File: rtl/rtc_pulse_stretch.sv
module rtc_pulse_stretch #(
   parameter int WIDTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   input  logic start,
   output logic active
);
   localparam int CW = $clog2(WIDTH + 1);

   logic [CW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      remain <= '0;
      else if (clr)                    remain <= '0;
      else if (start)                  remain <= CW'(WIDTH);
      else if (tick && remain != '0)   remain <= remain - 1'b1;
   end

   assign active = (remain != '0);
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
   import rtc_pkg::*;
#(
   parameter int STAGES       = 15,
   parameter int HOLD_STAGES  = 5,
   parameter int BUSY_LEAD    = 14,
   parameter int BUSY_GRACE   = 8,
   parameter int FAST_HALF    = 16,
   parameter int MARK_WIDTH   = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       osc_tick,
   input  logic       div_clr,
   input  logic       halt,
   input  logic       sec_carry,
   input  logic       min_carry,
   output logic       cnt_strobe,
   output logic       busy_n,
   output logic       acc_inhibit,
   output logic [3:0] ref_out
);
   localparam int FAST_BIT = $clog2(FAST_HALF);

   generate
      if (STAGES < 2 || STAGES > 30) begin : g_bad_stages
         $error("rtc_prescaler: STAGES out of range");
      end
      if (HOLD_STAGES < 1 || HOLD_STAGES > STAGES) begin : g_bad_hold
         $error("rtc_prescaler: HOLD_STAGES out of range");
      end
      if (BUSY_GRACE >= BUSY_LEAD || BUSY_LEAD >= (1 << STAGES)) begin : g_bad_busy
         $error("rtc_prescaler: busy window inconsistent");
      end
      if ((1 << FAST_BIT) != FAST_HALF || FAST_BIT >= STAGES) begin : g_bad_fast
         $error("rtc_prescaler: FAST_HALF must be a power of two inside the divider");
      end
      if (MARK_WIDTH < 1) begin : g_bad_mark
         $error("rtc_prescaler: MARK_WIDTH must be positive");
      end
   endgenerate

   logic [STAGES-1:0] q_nxt;
   logic              wrap;
   ref_vec_t          mark_start;
   ref_vec_t          mark_active;
   logic              fast_q;
   logic              strobe_q;

   rtc_divider #(
      .STAGES      (STAGES),
      .HOLD_STAGES (HOLD_STAGES)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (osc_tick),
      .clr   (div_clr),
      .q_nxt (q_nxt),
      .wrap  (wrap)
   );

   rtc_busy_window #(
      .STAGES (STAGES),
      .LEAD   (BUSY_LEAD),
      .GRACE  (BUSY_GRACE)
   ) u_busy (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (div_clr),
      .q_nxt   (q_nxt),
      .busy_n  (busy_n),
      .inhibit (acc_inhibit)
   );

   always_comb begin
      mark_start           = '0;
      mark_start[REF_SEC]  = wrap;
      mark_start[REF_MIN]  = wrap & sec_carry & ~halt;
      mark_start[REF_HOUR] = wrap & min_carry & ~halt;
   end

   assign mark_active[REF_FAST] = 1'b0;

   generate
      for (genvar i = REF_SEC; i < REF_N; i++) begin : g_mark
         rtc_pulse_stretch #(
            .WIDTH (MARK_WIDTH)
         ) u_mark (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (div_clr),
            .tick   (osc_tick),
            .start  (mark_start[i]),
            .active (mark_active[i])
         );
         assign ref_out[i] = ~mark_active[i];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fast_q   <= 1'b1;
         strobe_q <= 1'b0;
      end else begin
         fast_q   <= ~q_nxt[FAST_BIT];
         strobe_q <= wrap & ~halt;
      end
   end

   assign ref_out[REF_FAST] = fast_q & ~mark_active[REF_FAST];
   assign cnt_strobe        = strobe_q;
endmodule

// File: rtl/rtc_prescaler_chk.sv
module rtc_prescaler_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       div_clr,
   input logic       halt,
   input logic       cnt_strobe,
   input logic       busy_n,
   input logic       acc_inhibit,
   input logic [3:0] ref_out
);
   a_r4_inhibit_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
      acc_inhibit |-> !busy_n);

   a_r1_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_strobe |=> !cnt_strobe);

   a_r3_busy_ends_at_count: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_strobe |-> $rose(busy_n));

   a_r2_halt_blocks_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_strobe |-> !$past(halt));

   a_r5_clear_holds: assert property (@(posedge clk) disable iff (!rst_n)
      $past(div_clr) |-> (busy_n && !acc_inhibit && !cnt_strobe && ref_out[1]));

   a_r9_minute_with_second: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ref_out[2]) |-> $fell(ref_out[1]));

   a_r9_hour_with_second: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ref_out[3]) |-> $fell(ref_out[1]));

   a_r8_second_at_count: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_strobe |-> $fell(ref_out[1]));
endmodule

bind rtc_prescaler rtc_prescaler_chk chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .div_clr     (div_clr),
   .halt        (halt),
   .cnt_strobe  (cnt_strobe),
   .busy_n      (busy_n),
   .acc_inhibit (acc_inhibit),
   .ref_out     (ref_out)
);

// File: tb/rtc_prescaler_tb.sv
module rtc_prescaler_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_tick = 1'b0;
   logic       div_clr = 1'b0;
   logic       halt = 1'b0;
   logic       sec_carry = 1'b0;
   logic       min_carry = 1'b0;
   logic       cnt_strobe;
   logic       busy_n;
   logic       acc_inhibit;
   logic [3:0] ref_out;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;
   bit cmp_en = 0;

   // behavioural reference state
   int  mq = 0;
   int  c_sec = 0, c_min = 0, c_hour = 0;
   bit  e_strobe = 0, e_busy = 1, e_inh = 0;
   bit [3:0] e_ref = 4'b1111;
   string t_str = "R10", t_busy = "R10", t_inh = "R10";
   string t_fast = "R10", t_sec = "R10", t_mark = "R10";

   always #4 clk = ~clk;

   rtc_prescaler dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .osc_tick    (osc_tick),
      .div_clr     (div_clr),
      .halt        (halt),
      .sec_carry   (sec_carry),
      .min_carry   (min_carry),
      .cnt_strobe  (cnt_strobe),
      .busy_n      (busy_n),
      .acc_inhibit (acc_inhibit),
      .ref_out     (ref_out)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      bit w;
      cmp_en <= 1'b1;
      if (!rst_n) begin
         mq = 0; c_sec = 0; c_min = 0; c_hour = 0;
         e_strobe = 0; e_busy = 1; e_inh = 0; e_ref = 4'b1111;
         t_str = "R10"; t_busy = "R10"; t_inh = "R10";
         t_fast = "R10"; t_sec = "R10"; t_mark = "R10";
      end else begin
         w = osc_tick && !div_clr && (mq == 32767);
         e_strobe = w && !halt;
         t_str = halt ? "R2" : "R1";
         if (div_clr) mq = (mq % 1024 + (osc_tick ? 1 : 0)) % 1024;
         else         mq = (mq + (osc_tick ? 1 : 0)) % 32768;
         e_busy = div_clr ? 1 : !(mq >= 32754);
         e_inh  = div_clr ? 0 : (mq >= 32762);
         e_ref[0] = ((mq / 16) % 2) == 0;
         if (div_clr) begin
            c_sec = 0; c_min = 0; c_hour = 0;
         end else begin
            if (w) c_sec = 4; else if (osc_tick && c_sec > 0) c_sec--;
            if (w && sec_carry && !halt) c_min = 4; else if (osc_tick && c_min > 0) c_min--;
            if (w && min_carry && !halt) c_hour = 4; else if (osc_tick && c_hour > 0) c_hour--;
         end
         e_ref[1] = (c_sec == 0);
         e_ref[2] = (c_min == 0);
         e_ref[3] = (c_hour == 0);
         t_busy = div_clr ? "R5" : "R3";
         t_inh  = div_clr ? "R5" : "R4";
         t_fast = "R7";
         t_sec  = div_clr ? "R5" : "R8";
         t_mark = div_clr ? "R5" : "R9";
      end
   end

   always @(negedge clk) begin
      if (cmp_en && !finished) begin
         chk(t_str,  "cnt_strobe",  cnt_strobe,  e_strobe);
         chk(t_busy, "busy_n",      busy_n,      e_busy);
         chk(t_inh,  "acc_inhibit", acc_inhibit, e_inh);
         chk(t_fast, "ref_out[0]",  ref_out[0],  e_ref[0]);
         chk(t_sec,  "ref_out[1]",  ref_out[1],  e_ref[1]);
         chk(t_mark, "ref_out[2]",  ref_out[2],  e_ref[2]);
         chk(t_mark, "ref_out[3]",  ref_out[3],  e_ref[3]);
      end
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int n;
      int lo;
      bit [6:0] snap;
      repeat (3) @(negedge clk);
      // R10: reset values
      chk("R10", "reset busy_n", busy_n, 1);
      chk("R10", "reset ref_out", ref_out, 4'b1111);
      rst_n = 1'b1;

      // first second with irregular ticks, seconds carry pending
      sec_carry = 1'b1;
      forever begin
         @(negedge clk);
         if (cnt_strobe) break;
         osc_tick = ($urandom % 8) != 0;
      end

      // second second: ticks on every clock, minute carry too (R1 interval)
      osc_tick = 1'b1;
      min_carry = 1'b1;
      n = 0;
      forever begin
         @(negedge clk);
         n++;
         if (cnt_strobe) break;
      end
      chk("R1", "strobe interval", n, 32768);
      sec_carry = 1'b0;
      min_carry = 1'b0;

      // idle ticks: nothing may move (R11)
      osc_tick = 1'b0;
      @(negedge clk);
      snap = {cnt_strobe, busy_n, acc_inhibit, ref_out};
      repeat (50) @(negedge clk);
      chk("R11", "outputs with no tick", {cnt_strobe, busy_n, acc_inhibit, ref_out}, snap);
      osc_tick = 1'b1;

      // halted wrap with carry pending (R2, R9)
      halt = 1'b1;
      sec_carry = 1'b1;
      n = 0;
      forever begin
         @(negedge clk);
         if (busy_n) n = 0; else n++;
         if (!busy_n && n == 1) break;
      end
      forever begin
         @(negedge clk);
         if (busy_n) break;
      end
      chk("R2", "strobe while halted", cnt_strobe, 0);
      chk("R8", "second marker while halted", ref_out[1], 0);
      chk("R9", "minute marker while halted", ref_out[2], 1);

      // enter next busy window, clear inside it (R5)
      forever begin
         @(negedge clk);
         if (!busy_n) break;
      end
      repeat (10) @(negedge clk);
      chk("R4", "inhibit after grace", acc_inhibit, 1);
      div_clr = 1'b1;
      @(negedge clk);
      chk("R5", "busy_n under clear", busy_n, 1);
      chk("R5", "inhibit under clear", acc_inhibit, 0);
      repeat (3000) @(negedge clk);
      halt = 1'b0;
      sec_carry = 1'b0;
      div_clr = 1'b0;
      lo = mq % 1024;
      n = 0;
      forever begin
         @(negedge clk);
         n++;
         if (cnt_strobe) break;
      end
      chk("R6", "cycles from release to strobe", n, 32768 - lo);
      repeat (8) @(negedge clk);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule